// File: doc/BRIEF.md
# Macroblock Address Mapper

This block turns a macroblock position inside a reference frame into a physical DRAM location. A request carries a reference-frame number and a two-dimensional macroblock index (x, y), where (0, 0) is the top-left macroblock and (FW-1, FH-1) is the bottom-right one. Every reference frame owns a private pair of banks. Because of this, the parallel SAD engines, one per reference frame, can fetch from their own frames at the same time without bank conflicts.

Inside a frame, the parity of x selects one bank of the pair, so horizontally neighbouring macroblocks fall into different banks. Each bank holds its half of the columns, stored one macroblock row after another. Every word-line of a bank packs S macroblocks. The mapper returns the physical bank, the word-line (row) address and the slot inside that word-line, one cycle after the request. It accepts a new request on every cycle. A request that points outside the frame, or at a frame number that does not exist, is rejected with an error flag instead of a result.

Top module: `mb_addr_map`

## Requirements
- R1: While reset is high, and on the first cycle after it falls with no request pending, rsp_valid and rsp_err are both low.
- R2: An in-range request presented on a rising edge produces rsp_valid high on the following cycle, and requests on consecutive cycles produce results on consecutive cycles.
- R3: The physical bank is 2*frame + (x mod 2), formed as {frame, x[0]}.
- R4: The slot is (x div 2) mod S, so it stays below S.
- R5: The row is y*L + (x div 2) div S, where L = ceil(ceil(FW/2)/S) word-lines per macroblock row. With the defaults (FW=22, S=4), L=3.
- R6: A request with x >= FW gives rsp_err high and rsp_valid low one cycle later.
- R7: A request with y >= FH gives rsp_err high and rsp_valid low one cycle later.
- R8: A request with frame >= M gives rsp_err high and rsp_valid low one cycle later.
- R9: A cycle with no request gives rsp_valid and rsp_err low one cycle later. Whenever rsp_valid is low, rsp_bank, rsp_row and rsp_slot read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_frame | input | FRW = clog2(M), min 1 (2) | Reference-frame number |
| req_x | input | XW = clog2(FW), min 1 (5) | Macroblock column |
| req_y | input | YW = clog2(FH), min 1 (5) | Macroblock row |
| rsp_valid | output | 1 | A mapped address is presented |
| rsp_err | output | 1 | The previous request was out of range |
| rsp_bank | output | FRW+1 (3) | Physical bank index |
| rsp_row | output | RW = clog2(FH*L), min 1 (6) | Word-line address inside the bank |
| rsp_slot | output | SW = clog2(S), min 1 (2) | Macroblock slot inside the word-line |

## Verification
The pipeline holds a single register stage, so any corrupted internal value shows up at the ports on the cycle right after the request that caused it. Nothing can stay hidden longer than that. A wrong bank bit, slot or row shows as a mismatch on that one result. A bad range decision shows as rsp_valid and rsp_err swapped. A stale or uncleared register shows as non-zero address fields, or a raised flag, on an idle cycle. The sweep across every column of a row walks the slot through all its values and the row across each word-line boundary.

// File: rtl/mb_map_pkg.sv
package mb_map_pkg;

    function automatic int width_of(input int n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

    function automatic int ceil_div(input int a, input int b);
        return (a + b - 1) / b;
    endfunction

    function automatic bit is_pow2(input int n);
        return (n > 0) && ((n & (n - 1)) == 0);
    endfunction

    function automatic int floor_log2(input int n);
        int r;
        r = 0;
        while ((n >> (r + 1)) > 0) r++;
        return r;
    endfunction

    typedef enum logic [1:0] {
        MAP_IDLE = 2'b00,
        MAP_OK   = 2'b01,
        MAP_REJ  = 2'b10
    } map_kind_e;

endpackage

// File: rtl/mb_range_chk.sv
module mb_range_chk #(
    parameter int FW  = 22,
    parameter int FH  = 18,
    parameter int M   = 3,
    parameter int XW  = 5,
    parameter int YW  = 5,
    parameter int FRW = 2
) (
    input  logic [FRW-1:0] frame,
    input  logic [XW-1:0]  x,
    input  logic [YW-1:0]  y,
    output logic           in_range
);
    logic x_ok, y_ok, f_ok;

    always_comb begin
        x_ok = (32'(x) < FW);
        y_ok = (32'(y) < FH);
        f_ok = (32'(frame) < M);
        in_range = x_ok && y_ok && f_ok;
    end
endmodule

// File: rtl/mb_addr_calc.sv
module mb_addr_calc #(
    parameter int S   = 4,
    parameter int LPR = 3,
    parameter int XW  = 5,
    parameter int YW  = 5,
    parameter int FRW = 2,
    parameter int RW  = 6,
    parameter int SW  = 2
) (
    input  logic [FRW-1:0] frame,
    input  logic [XW-1:0]  x,
    input  logic [YW-1:0]  y,
    output logic [FRW:0]   bank,
    output logic [RW-1:0]  row,
    output logic [SW-1:0]  slot
);
    import mb_map_pkg::*;

    logic [31:0] col;
    logic [31:0] line_off;
    logic [31:0] slot_w;

    assign col  = 32'(x) >> 1;
    assign bank = {frame, x[0]};

    generate
        if (is_pow2(S)) begin : g_shift
            localparam int SLOG = floor_log2(S);
            assign line_off = col >> SLOG;
            assign slot_w   = col & 32'(S - 1);
        end else begin : g_divide
            assign line_off = col / 32'(S);
            assign slot_w   = col % 32'(S);
        end
    endgenerate

    always_comb begin
        row  = RW'(32'(y) * 32'(LPR) + line_off);
        slot = SW'(slot_w);
    end
endmodule

// File: rtl/mb_addr_map.sv
module mb_addr_map
    import mb_map_pkg::*;
#(
    parameter int FW = 22,
    parameter int FH = 18,
    parameter int S  = 4,
    parameter int M  = 3,
    localparam int XW  = width_of(FW),
    localparam int YW  = width_of(FH),
    localparam int FRW = width_of(M),
    localparam int BW  = FRW + 1,
    localparam int LPR = ceil_div(ceil_div(FW, 2), S),
    localparam int RW  = width_of(FH * LPR),
    localparam int SW  = width_of(S)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           req_valid,
    input  logic [FRW-1:0] req_frame,
    input  logic [XW-1:0]  req_x,
    input  logic [YW-1:0]  req_y,
    output logic           rsp_valid,
    output logic           rsp_err,
    output logic [BW-1:0]  rsp_bank,
    output logic [RW-1:0]  rsp_row,
    output logic [SW-1:0]  rsp_slot
);
    typedef struct packed {
        map_kind_e       kind;
        logic [BW-1:0]   bank;
        logic [RW-1:0]   row;
        logic [SW-1:0]   slot;
    } rsp_t;

    logic          in_range;
    logic [BW-1:0] c_bank;
    logic [RW-1:0] c_row;
    logic [SW-1:0] c_slot;
    rsp_t          nxt, cur;

    mb_range_chk #(
        .FW(FW), .FH(FH), .M(M), .XW(XW), .YW(YW), .FRW(FRW)
    ) u_range (
        .frame(req_frame), .x(req_x), .y(req_y), .in_range(in_range)
    );

    mb_addr_calc #(
        .S(S), .LPR(LPR), .XW(XW), .YW(YW), .FRW(FRW), .RW(RW), .SW(SW)
    ) u_calc (
        .frame(req_frame), .x(req_x), .y(req_y),
        .bank(c_bank), .row(c_row), .slot(c_slot)
    );

    always_comb begin
        nxt = '0;
        if (req_valid) begin
            if (in_range) begin
                nxt.kind = MAP_OK;
                nxt.bank = c_bank;
                nxt.row  = c_row;
                nxt.slot = c_slot;
            end else begin
                nxt.kind = MAP_REJ;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= '0;
        else     cur <= nxt;
    end

    assign rsp_valid = (cur.kind == MAP_OK);
    assign rsp_err   = (cur.kind == MAP_REJ);
    assign rsp_bank  = cur.bank;
    assign rsp_row   = cur.row;
    assign rsp_slot  = cur.slot;
endmodule

// File: rtl/mb_addr_map_chk.sv
module mb_addr_map_chk
    import mb_map_pkg::*;
#(
    parameter int FW = 22,
    parameter int FH = 18,
    parameter int S  = 4,
    parameter int M  = 3,
    localparam int XW  = width_of(FW),
    localparam int YW  = width_of(FH),
    localparam int FRW = width_of(M),
    localparam int BW  = FRW + 1,
    localparam int LPR = ceil_div(ceil_div(FW, 2), S),
    localparam int RW  = width_of(FH * LPR),
    localparam int SW  = width_of(S)
) (
    input logic           clk,
    input logic           rst,
    input logic           req_valid,
    input logic [FRW-1:0] req_frame,
    input logic [XW-1:0]  req_x,
    input logic [YW-1:0]  req_y,
    input logic           rsp_valid,
    input logic           rsp_err,
    input logic [BW-1:0]  rsp_bank,
    input logic [RW-1:0]  rsp_row,
    input logic [SW-1:0]  rsp_slot
);
    logic x_bad, y_bad, f_bad, good_req;
    assign x_bad    = 32'(req_x) >= FW;
    assign y_bad    = 32'(req_y) >= FH;
    assign f_bad    = 32'(req_frame) >= M;
    assign good_req = req_valid && !x_bad && !y_bad && !f_bad;

    assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
        good_req |=> rsp_valid && !rsp_err);

    assert_bank_R3: assert property (@(posedge clk) disable iff (rst)
        good_req |=> rsp_bank == {$past(req_frame), $past(req_x[0])});

    assert_slot_R4: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> 32'(rsp_slot) < S);

    assert_row_R5: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> 32'(rsp_row) < FH * LPR);

    assert_xrange_R6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && x_bad) |=> rsp_err && !rsp_valid);

    assert_yrange_R7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && y_bad) |=> rsp_err && !rsp_valid);

    assert_frange_R8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && f_bad) |=> rsp_err && !rsp_valid);

    assert_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid && !rsp_err);

    assert_zero_fields_R9: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> (rsp_bank == '0) && (rsp_row == '0) && (rsp_slot == '0));
endmodule

bind mb_addr_map mb_addr_map_chk #(
    .FW(FW), .FH(FH), .S(S), .M(M)
) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_frame(req_frame),
    .req_x(req_x), .req_y(req_y), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .rsp_bank(rsp_bank), .rsp_row(rsp_row), .rsp_slot(rsp_slot)
);

// File: tb/test_mb_addr_map.sv
module test_mb_addr_map;
    localparam int FW  = 22;
    localparam int FH  = 18;
    localparam int S   = 4;
    localparam int M   = 3;
    localparam int XW  = 5;
    localparam int YW  = 5;
    localparam int FRW = 2;
    localparam int BW  = 3;
    localparam int RW  = 6;
    localparam int SW  = 2;
    localparam int LPR = (((FW + 1) / 2) + S - 1) / S;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           req_valid = 1'b0;
    logic [FRW-1:0] req_frame = '0;
    logic [XW-1:0]  req_x = '0;
    logic [YW-1:0]  req_y = '0;
    logic           rsp_valid, rsp_err;
    logic [BW-1:0]  rsp_bank;
    logic [RW-1:0]  rsp_row;
    logic [SW-1:0]  rsp_slot;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    typedef struct {
        bit    idle;
        bit    err;
        int    bank;
        int    row;
        int    slot;
        string tag;
    } exp_t;

    exp_t expq[$];

    always #5 clk = ~clk;

    mb_addr_map #(.FW(FW), .FH(FH), .S(S), .M(M)) i_mb_addr_map (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_frame(req_frame),
        .req_x(req_x), .req_y(req_y), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
        .rsp_bank(rsp_bank), .rsp_row(rsp_row), .rsp_slot(rsp_slot)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic send(input int f, input int x, input int y);
        exp_t e;
        @(negedge clk);
        req_valid = 1'b1;
        req_frame = FRW'(f);
        req_x     = XW'(x);
        req_y     = YW'(y);
        e.idle = 0;
        e.err  = (x >= FW) || (y >= FH) || (f >= M);
        e.tag  = (x >= FW) ? "R6" : (y >= FH) ? "R7" : (f >= M) ? "R8" : "R2";
        e.bank = 2 * f + (x % 2);
        e.slot = (x / 2) % S;
        e.row  = y * LPR + (x / 2) / S;
        expq.push_back(e);
    endtask

    task automatic idle();
        exp_t e;
        @(negedge clk);
        req_valid = 1'b0;
        req_frame = '0;
        req_x     = '0;
        req_y     = '0;
        e.idle = 1; e.err = 0; e.bank = 0; e.row = 0; e.slot = 0; e.tag = "R9";
        expq.push_back(e);
    endtask

    // Monitor: compares each result 2 ns after the edge that registered it.
    always @(posedge clk) begin
        #2;
        if (expq.size() > 0) begin
            exp_t e;
            e = expq.pop_front();
            if (e.idle) begin
                chk(!rsp_valid && !rsp_err, "R9 flags", {30'd0, rsp_valid, rsp_err}, 0);
                chk(rsp_bank == 0 && rsp_row == 0 && rsp_slot == 0, "R9 fields",
                    int'(rsp_row), 0);
            end else if (e.err) begin
                chk(rsp_err && !rsp_valid, e.tag, {30'd0, rsp_valid, rsp_err}, 1);
            end else begin
                chk(rsp_valid && !rsp_err, "R2 valid", {30'd0, rsp_valid, rsp_err}, 2);
                chk(int'(rsp_bank) == e.bank, "R3 bank", int'(rsp_bank), e.bank);
                chk(int'(rsp_slot) == e.slot, "R4 slot", int'(rsp_slot), e.slot);
                chk(int'(rsp_row) == e.row, "R5 row", int'(rsp_row), e.row);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL R2 watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: request held during reset must not appear
        @(negedge clk);
        req_valid = 1'b1; req_frame = 2'd1; req_x = 5'd3; req_y = 5'd2;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!rsp_valid && !rsp_err, "R1 in reset", {30'd0, rsp_valid, rsp_err}, 0);
        req_valid = 1'b0; req_frame = '0; req_x = '0; req_y = '0;
        rst = 1'b0;
        @(negedge clk);
        chk(!rsp_valid && !rsp_err, "R1 after reset", {30'd0, rsp_valid, rsp_err}, 0);

        // Corners
        send(0, 0, 0);
        send(M - 1, FW - 1, FH - 1);
        idle();
        // Back-to-back sweep of one macroblock row (R2..R5)
        for (int x = 0; x < FW; x++) send(1, x, 5);
        idle();
        // Every frame, mixed positions
        for (int f = 0; f < M; f++) begin
            send(f, 7, 0);
            send(f, 8, FH - 1);
            send(f, 15, 9);
        end
        idle();
        // Out-of-range requests interleaved with good ones
        send(0, FW, 0);        // R6
        send(2, 31, 3);        // R6
        send(1, 4, 4);
        send(0, 2, FH);        // R7
        send(1, 2, 31);        // R7
        send(M, 2, 2);         // R8
        send(2, 9, 11);
        idle();
        send(0, 1, 1);
        idle();
        idle();
        repeat (3) @(posedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule